// File: doc/BRIEF.md
# GPIO Bank with Interrupt Detection

This block is one bank of general-purpose pins, `NUM_PINS` wide (9 to 31 pins), controlled through a small set of word-wide registers. Each pin has three controls: a driven value, a drive enable that controls the pad's tri-state buffer, and a readback of the pad that passes through a two-stage synchroniser. Software writes a register by presenting its select code and data with `wrEn` high for one cycle. Reads are combinational from `regAddr`.

Each pin also has interrupt detection. A pin is either edge-triggered or level-triggered, and a polarity bit selects rising or falling for edges and high or low for levels. Every detected condition is latched into a sticky pending bit, and this includes level conditions. The pending bit is set whether or not the pin's interrupt enable is on. Software clears pending bits by writing ones to the clear register. The single interrupt line is high while any pending pin is also enabled. There is no both-edge mode: software gets that behaviour by toggling the polarity bit after each event.

Top module: `gpio_bank`

## Requirements
- R1: After reset, drive enables, interrupt enables and pending bits read 0. Trigger-mode and polarity read all ones (edge, rising). `padOe` is 0 and `irqOut` is 0.
- R2: `padOe` equals the drive-enable register. `padOut` carries the value register only on pins whose enable is 1 and is 0 on other pins.
- R3: The input register (select 2) shows `padIn` two clock edges after it changes, whatever the drive enable is.
- R4: An edge-mode pin (trigger bit 1) sets its pending bit on a rising synchronised transition when polarity is 1, and on a falling transition when polarity is 0.
- R5: A level-mode pin (trigger bit 0) sets its pending bit while the synchronised input equals its polarity bit. The bit stays set after the level goes away.
- R6: Writing 1 to a bit of the clear register (select 6) clears that pending bit. Writing 0 leaves it unchanged. The clear register reads 0.
- R7: The pending register (select 7) shows raw pending bits regardless of the enable register (select 5). `irqOut` is the OR of pending AND enable.
- R8: When a detect condition and a clear of the same bit fall in the same cycle, the bit stays pending.
- R9: Register bits at and above `NUM_PINS` read 0, and writes to them are ignored.
- R10: The value (0), drive-enable (1), trigger-mode (3), polarity (4) and enable (5) registers read back what was last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe for the register selected by regAddr |
| regAddr | input | 3 | Register select |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data of the selected register |
| padIn | input | NUM_PINS | Pad input levels |
| padOut | output | NUM_PINS | Pad output values, gated by drive enable |
| padOe | output | NUM_PINS | Pad drive enables |
| irqOut | output | 1 | Combined interrupt |

## Verification
The hardest case to reach from the ports is a clear that arrives in the same cycle as a fresh detect on that pin. The stimulus creates it by holding a level-mode pin at its active level while clearing it, so a detect is present on every edge, including the edge of the clear. Randomised rounds then vary trigger mode, polarity, enable and the pad transition. In each round the bench clears all pending bits, applies one new pad pattern, and compares the pending register and `irqOut` against a model of level and edge hits.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    SEL_OUT  = 3'd0,
    SEL_OE   = 3'd1,
    SEL_IN   = 3'd2,
    SEL_TRIG = 3'd3,
    SEL_POL  = 3'd4,
    SEL_IEN  = 3'd5,
    SEL_CLR  = 3'd6,
    SEL_STAT = 3'd7
  } regSel_e;

  typedef struct packed {
    logic wrOut;
    logic wrOe;
    logic wrTrig;
    logic wrPol;
    logic wrIen;
    logic wrClr;
  } wrStrobe_t;
endpackage

// File: rtl/gpio_bank_sync.sv
module gpio_bank_sync #(
  parameter int NUM_PINS = 16,
  parameter int STAGES   = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_PINS-1:0] asyncIn,
  output logic [NUM_PINS-1:0] syncOut
);
  logic [NUM_PINS-1:0] stage [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) stage[s] <= '0;
          else       stage[s] <= asyncIn;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) stage[s] <= '0;
          else       stage[s] <= stage[s-1];
        end
      end
    end
  endgenerate

  assign syncOut = stage[STAGES-1];
endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_bank_pkg::*;
(
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] regAddr,
  output wrStrobe_t         strb
);
  always_comb begin
    strb = '0;
    if (wrEn) begin
      case (regSel_e'(regAddr))
        SEL_OUT:  strb.wrOut  = 1'b1;
        SEL_OE:   strb.wrOe   = 1'b1;
        SEL_TRIG: strb.wrTrig = 1'b1;
        SEL_POL:  strb.wrPol  = 1'b1;
        SEL_IEN:  strb.wrIen  = 1'b1;
        SEL_CLR:  strb.wrClr  = 1'b1;
        default:  strb = '0;
      endcase
    end
  end
endmodule

// File: rtl/gpio_bank_dp.sv
module gpio_bank_dp
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PINS = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  wrStrobe_t           strb,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic [NUM_PINS-1:0] wrBits,
  input  logic [NUM_PINS-1:0] padSync,
  output logic [DATA_W-1:0]   rdData,
  output logic [NUM_PINS-1:0] padOut,
  output logic [NUM_PINS-1:0] padOe,
  output logic                irqOut,
  output logic [NUM_PINS-1:0] statusVec,
  output logic [NUM_PINS-1:0] eventVec
);
  logic [NUM_PINS-1:0] outQ, oeQ, trigQ, polQ, ienQ, statQ, prevQ;
  logic [NUM_PINS-1:0] clrMask;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outQ  <= '0;
      oeQ   <= '0;
      trigQ <= '1;
      polQ  <= '1;
      ienQ  <= '0;
    end else begin
      if (strb.wrOut)  outQ  <= wrBits;
      if (strb.wrOe)   oeQ   <= wrBits;
      if (strb.wrTrig) trigQ <= wrBits;
      if (strb.wrPol)  polQ  <= wrBits;
      if (strb.wrIen)  ienQ  <= wrBits;
    end
  end

  // Per-pin detector: level hit or qualified edge hit
  generate
    for (genvar i = 0; i < NUM_PINS; i++) begin : g_det
      logic levelHit, riseHit, fallHit;
      assign levelHit    = ~trigQ[i] & ~(polQ[i] ^ padSync[i]);
      assign riseHit     = padSync[i] & ~prevQ[i];
      assign fallHit     = ~padSync[i] & prevQ[i];
      assign eventVec[i] = levelHit | (trigQ[i] & (polQ[i] ? riseHit : fallHit));
    end
  endgenerate

  assign clrMask = strb.wrClr ? wrBits : '0;

  // Set takes priority over a simultaneous clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statQ <= '0;
      prevQ <= '0;
    end else begin
      statQ <= (statQ & ~clrMask) | eventVec;
      prevQ <= padSync;
    end
  end

  always_comb begin
    rdData = '0;
    case (regSel_e'(regAddr))
      SEL_OUT:  rdData[NUM_PINS-1:0] = outQ;
      SEL_OE:   rdData[NUM_PINS-1:0] = oeQ;
      SEL_IN:   rdData[NUM_PINS-1:0] = padSync;
      SEL_TRIG: rdData[NUM_PINS-1:0] = trigQ;
      SEL_POL:  rdData[NUM_PINS-1:0] = polQ;
      SEL_IEN:  rdData[NUM_PINS-1:0] = ienQ;
      SEL_STAT: rdData[NUM_PINS-1:0] = statQ;
      default:  rdData = '0;
    endcase
  end

  assign padOut    = outQ & oeQ;
  assign padOe     = oeQ;
  assign irqOut    = |(statQ & ienQ);
  assign statusVec = statQ;
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PINS = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [2:0]          regAddr,
  input  logic [31:0]         wrData,
  output logic [31:0]         rdData,
  input  logic [NUM_PINS-1:0] padIn,
  output logic [NUM_PINS-1:0] padOut,
  output logic [NUM_PINS-1:0] padOe,
  output logic                irqOut
);
  wrStrobe_t           strb;
  logic [NUM_PINS-1:0] padSync;
  logic [NUM_PINS-1:0] statusVec;
  logic [NUM_PINS-1:0] eventVec;
  logic                unusedWrHi;

  assign unusedWrHi = ^wrData[DATA_W-1:NUM_PINS];

  gpio_bank_ctrl u_ctrl (
    .wrEn    (wrEn),
    .regAddr (regAddr),
    .strb    (strb)
  );

  gpio_bank_sync #(.NUM_PINS(NUM_PINS), .STAGES(2)) u_sync (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn (padIn),
    .syncOut (padSync)
  );

  gpio_bank_dp #(.NUM_PINS(NUM_PINS)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .regAddr   (regAddr),
    .wrBits    (wrData[NUM_PINS-1:0]),
    .padSync   (padSync),
    .rdData    (rdData),
    .padOut    (padOut),
    .padOe     (padOe),
    .irqOut    (irqOut),
    .statusVec (statusVec),
    .eventVec  (eventVec)
  );
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PINS = 16
) (
  input logic                clk,
  input logic                rstN,
  input logic                wrEn,
  input logic [2:0]          regAddr,
  input logic [31:0]         wrData,
  input logic [NUM_PINS-1:0] padOe,
  input logic                irqOut,
  input logic [NUM_PINS-1:0] statusVec,
  input logic [NUM_PINS-1:0] eventVec
);
  // R1: first cycle out of reset is quiet
  a_r1_reset_quiet: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (padOe == '0 && !irqOut));

  // R2: drive enable follows its register write
  a_r2_oe_follows_write: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && regAddr == SEL_OE) |=> (padOe == $past(wrData[NUM_PINS-1:0])));

  // R5: pending bits only drop through the clear register
  a_r5_status_sticky: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && regAddr == SEL_CLR) |=> ((statusVec & $past(statusVec)) == $past(statusVec)));

  // R8: a detected event always lands in status, even against a clear
  a_r8_event_sets_status: assert property (@(posedge clk) disable iff (!rstN)
    (|eventVec) |=> ((statusVec & $past(eventVec)) == $past(eventVec)));

  // R7: masking everything silences the interrupt line
  a_r7_mask_all_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && regAddr == SEL_IEN && wrData[NUM_PINS-1:0] == '0) |=> !irqOut);
endmodule

bind gpio_bank gpio_bank_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .wrEn      (wrEn),
  .regAddr   (regAddr),
  .wrData    (wrData),
  .padOe     (padOe),
  .irqOut    (irqOut),
  .statusVec (statusVec),
  .eventVec  (eventVec)
);

// File: tb/gpio_bank_test.sv
module gpio_bank_test;
  localparam int W = 16;
  localparam logic [31:0] WMASK = 32'h0000_FFFF;

  logic          clk = 1'b0;
  logic          rstN;
  logic          wrEn;
  logic [2:0]    regAddr;
  logic [31:0]   wrData;
  logic [31:0]   rdData;
  logic [W-1:0]  padIn;
  logic [W-1:0]  padOut;
  logic [W-1:0]  padOe;
  logic          irqOut;

  int testsRun = 0;
  int testsFailed = 0;

  always #2 clk = ~clk;

  gpio_bank #(.NUM_PINS(W)) uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .regAddr(regAddr), .wrData(wrData),
    .rdData(rdData), .padIn(padIn), .padOut(padOut), .padOe(padOe), .irqOut(irqOut)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wrReg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rdReg(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = rdData;
  endtask

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [W-1:0] levelAct(input logic [W-1:0] v, input logic [W-1:0] trig,
                                            input logic [W-1:0] pol);
    return ~trig & ~(pol ^ v);
  endfunction

  function automatic logic [W-1:0] edgeAct(input logic [W-1:0] o, input logic [W-1:0] n,
                                           input logic [W-1:0] trig, input logic [W-1:0] pol);
    return trig & ((pol & ~o & n) | (~pol & o & ~n));
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    testsRun++;
    testsFailed++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [W-1:0] oldPad, newPad, trig, pol, ien, expStat;
    void'($urandom(32'd1234));
    rstN = 1'b1; wrEn = 1'b0; regAddr = '0; wrData = '0; padIn = '0;
    #1 rstN = 1'b0;
    waitN(3);
    rstN = 1'b1;
    waitN(1);

    // R1 reset state
    rdReg(3'd1, d); check("R1 oe", d, 32'h0);
    rdReg(3'd5, d); check("R1 ien", d, 32'h0);
    rdReg(3'd7, d); check("R1 stat", d, 32'h0);
    rdReg(3'd3, d); check("R1 trig", d, WMASK);
    rdReg(3'd4, d); check("R1 pol", d, WMASK);
    check("R1 padOe", 32'(padOe), 32'h0);
    check("R1 irq", 32'(irqOut), 32'h0);

    // R10 readback, R9 upper bits
    wrReg(3'd0, 32'hFFFF_FFFF); rdReg(3'd0, d); check("R9 out upper", d, WMASK);
    wrReg(3'd5, 32'h1234_5A5A); rdReg(3'd5, d); check("R10 ien", d, 32'h0000_5A5A);
    wrReg(3'd5, 32'h0);
    rdReg(3'd6, d); check("R6 clr reads zero", d, 32'h0);

    // R2 drive
    wrReg(3'd0, 32'h0000_F0F0); wrReg(3'd1, 32'h0000_FF00);
    check("R2 padOe", 32'(padOe), 32'h0000_FF00);
    check("R2 padOut", 32'(padOut), 32'h0000_F000);

    // R3 latency of input readback
    @(negedge clk); padIn = 16'h00A5; regAddr = 3'd2;
    @(negedge clk); #1 check("R3 in one edge", rdData, 32'h0);
    @(negedge clk); #1 check("R3 in two edges", rdData, 32'h0000_00A5);
    padIn = '0; waitN(3);
    wrReg(3'd6, 32'hFFFF);  // drop rising events caused above

    // R5 level latch on pin 0, active high
    wrReg(3'd3, 32'h0000_FFFE);
    wrReg(3'd6, 32'hFFFF);
    @(negedge clk); padIn[0] = 1'b1; waitN(4);
    padIn[0] = 1'b0; waitN(4);
    rdReg(3'd7, d); check("R5 level sticky", d, 32'h1);
    check("R7 irq masked", 32'(irqOut), 32'h0);
    wrReg(3'd5, 32'h1); #1 check("R7 irq enabled", 32'(irqOut), 32'h1);
    wrReg(3'd6, 32'h0); rdReg(3'd7, d); check("R6 write zero no effect", d, 32'h1);
    wrReg(3'd6, 32'h1); rdReg(3'd7, d); check("R6 clear", d, 32'h0);
    check("R7 irq after clear", 32'(irqOut), 32'h0);

    // R8 set wins over clear
    @(negedge clk); padIn[0] = 1'b1; waitN(4);
    wrReg(3'd6, 32'h1); rdReg(3'd7, d); check("R8 set wins", d, 32'h1);
    @(negedge clk); padIn[0] = 1'b0; waitN(3);
    wrReg(3'd6, 32'hFFFF); rdReg(3'd7, d); check("R8 cleared once idle", d, 32'h0);

    // R4 directed edges
    wrReg(3'd3, 32'hFFFF); wrReg(3'd4, 32'h00FF); wrReg(3'd6, 32'hFFFF);
    @(negedge clk); padIn = 16'hFFFF; waitN(4);
    rdReg(3'd7, d); check("R4 rising", d, 32'h0000_00FF);
    wrReg(3'd6, 32'hFFFF);
    @(negedge clk); padIn = 16'h0000; waitN(4);
    rdReg(3'd7, d); check("R4 falling", d, 32'h0000_FF00);

    // Random rounds: R4 R5 R7 R3 R2
    oldPad = '0;
    for (int it = 0; it < 60; it++) begin
      trig = W'($urandom); pol = W'($urandom); ien = W'($urandom); newPad = W'($urandom);
      wrReg(3'd3, 32'(trig)); wrReg(3'd4, 32'(pol)); wrReg(3'd5, 32'(ien));
      waitN(1);
      wrReg(3'd6, 32'hFFFF);
      @(negedge clk); padIn = newPad; waitN(4);
      expStat = levelAct(oldPad, trig, pol) | levelAct(newPad, trig, pol)
              | edgeAct(oldPad, newPad, trig, pol);
      rdReg(3'd7, d); check("R4/R5 random stat", d, 32'(expStat));
      check("R7 random irq", 32'(irqOut), 32'(|(expStat & ien)));
      rdReg(3'd2, d); check("R3 random in", d, 32'(newPad));
      d = $urandom;
      wrReg(3'd0, d); wrReg(3'd1, ~d);
      check("R2 random padOut", 32'(padOut), (d & ~d) & WMASK);
      check("R2 random padOe", 32'(padOe), ~d & WMASK);
      oldPad = newPad;
    end

    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule